// File: doc/BRIEF.md
# Configuration capability list walker

The walker is a small sequencer that sits beside a configuration read path. Given a start pulse, it reads the status word of a device's 256-byte configuration space to learn whether a capability list exists. It then follows the pointer-linked chain of capability headers until it meets the express capability (identifier 0x10). From that structure's base it fetches the link capability and link status words and returns the maximum and the current link speed and width, with a flag for each width that says whether its code is a legal one.

All reads go through a simple port: a one-cycle read strobe with a dword address, followed, some cycles later, by a data-valid pulse carrying 32 bits of read data. The walker never writes. A hop limit guarantees completion when a corrupted chain loops back on itself. Results stay on the outputs until the next start.

Top module: `cfg_cap_walker`

## Requirements
- R1: The cycle after `start` is sampled while idle, `rd_req` is high with `rd_addr` = 1 (dword at byte 0x04, whose upper half is the status word at 0x06); a `start` while a walk is running has no effect on the reads or the results.
- R2: If status bit 4 (`rd_data[20]` of that read) is 0, the walk ends with `found` = 0 and `error` = 0 and no further read.
- R3: Otherwise the first pointer is `rd_data[7:0]` of dword 13 (byte 0x34) with bits [1:0] forced to 0; a masked pointer of 0 ends the walk with `found` = 0.
- R4: Each capability header read gives the identifier in `rd_data[7:0]` and the next pointer in `rd_data[15:8]` (bits [1:0] masked); identifier 0x10 matches, any other is skipped by following the next pointer, and a masked next pointer of 0 ends the walk with `found` = 0.
- R5: On a match, `cap_base` is the matching byte offset, and dword (base+0x0C)/4 supplies `max_speed` = `rd_data[3:0]` and `max_width` = `rd_data[9:4]`.
- R6: Then dword (base+0x10)/4 is read and its upper half (byte base+0x12) supplies `cur_speed` = `rd_data[19:16]` and `cur_width` = `rd_data[25:20]`; `found` goes to 1.
- R7: `max_width_ok` and `cur_width_ok` are 1 exactly when the width code is 1, 2, 4, 8, 12, 16 or 32.
- R8: When 48 headers have been read without a match and the next pointer is still nonzero, the walk ends with `error` = 1 and `found` = 0.
- R9: `done` is a one-cycle pulse in the cycle after the last read's `rd_valid`; `rd_req` is a one-cycle strobe and the next one waits for `rd_valid`; results hold after `done` and are cleared by the next accepted `start`.
- R10: After reset, `rd_req`, `done`, `found`, `error` and all result fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| rd_req | output | 1 | One-cycle read strobe |
| rd_addr | output | 6 | Dword address of the read |
| rd_valid | input | 1 | Read data valid pulse |
| rd_data | input | 32 | Read data |
| done | output | 1 | Walk finished pulse |
| found | output | 1 | Express capability located |
| error | output | 1 | Hop limit exceeded |
| cap_base | output | 8 | Byte offset of the express capability |
| max_speed | output | 4 | Maximum link speed code |
| max_width | output | 6 | Maximum link width code |
| max_width_ok | output | 1 | Maximum width code is legal |
| cur_speed | output | 4 | Current link speed code |
| cur_width | output | 6 | Negotiated link width code |
| cur_width_ok | output | 1 | Negotiated width code is legal |

## Verification
A read strobe follows one cycle after the accepted start or after the previous data-valid pulse, and `done` follows one cycle after the final data-valid pulse, so the walk length depends only on the number of reads and the responder latency. The bench polls for `done` on every falling edge and samples the results on that same edge. A monitor confirms that every `done` was preceded one cycle earlier by `rd_valid` and lasts a single cycle. The number of strobes per walk is compared with the count that the chain layout requires, under responder latencies of one to three cycles.

// File: rtl/cfg_cap_walker.sv
module cfg_cap_walker #(
  parameter int MAX_HOPS = 48,
  parameter logic [7:0] TARGET_ID = 8'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        rd_req,
  output logic [5:0]  rd_addr,
  input  logic        rd_valid,
  input  logic [31:0] rd_data,
  output logic        done,
  output logic        found,
  output logic        error,
  output logic [7:0]  cap_base,
  output logic [3:0]  max_speed,
  output logic [5:0]  max_width,
  output logic        max_width_ok,
  output logic [3:0]  cur_speed,
  output logic [5:0]  cur_width,
  output logic        cur_width_ok
);
  localparam int HOP_W = $clog2(MAX_HOPS + 1);
  localparam logic [5:0] STAT_DW = 6'd1;
  localparam logic [5:0] PTR_DW  = 6'd13;

  typedef enum logic [2:0] {S_IDLE, S_STAT, S_PTR, S_HDR, S_LCAP, S_LSTS} st_t;

  st_t              state;
  logic [7:0]       base;
  logic [HOP_W-1:0] hops;

  logic [7:0] ptr_in, nxt_in, id_in;
  logic       unused_bits;
  assign ptr_in      = {rd_data[7:2], 2'b00};
  assign id_in       = rd_data[7:0];
  assign nxt_in      = {rd_data[15:10], 2'b00};
  assign unused_bits = ^{rd_data[31:26], rd_data[9:8]};

  assign max_width_ok = max_width inside {6'd1, 6'd2, 6'd4, 6'd8, 6'd12, 6'd16, 6'd32};
  assign cur_width_ok = cur_width inside {6'd1, 6'd2, 6'd4, 6'd8, 6'd12, 6'd16, 6'd32};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      rd_req <= 1'b0;
      rd_addr <= '0;
      base <= '0;
      hops <= '0;
      done <= 1'b0;
      found <= 1'b0;
      error <= 1'b0;
      cap_base <= '0;
      max_speed <= '0;
      max_width <= '0;
      cur_speed <= '0;
      cur_width <= '0;
    end else begin
      rd_req <= 1'b0;
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          found <= 1'b0;
          error <= 1'b0;
          cap_base <= '0;
          max_speed <= '0;
          max_width <= '0;
          cur_speed <= '0;
          cur_width <= '0;
          state <= S_STAT;
          rd_req <= 1'b1;
          rd_addr <= STAT_DW;
        end
        S_STAT: if (rd_valid) begin
          if (rd_data[20]) begin
            state <= S_PTR;
            rd_req <= 1'b1;
            rd_addr <= PTR_DW;
          end else begin
            state <= S_IDLE;
            done <= 1'b1;
          end
        end
        S_PTR: if (rd_valid) begin
          if (ptr_in == 8'h00) begin
            state <= S_IDLE;
            done <= 1'b1;
          end else begin
            base <= ptr_in;
            hops <= '0;
            state <= S_HDR;
            rd_req <= 1'b1;
            rd_addr <= ptr_in[7:2];
          end
        end
        S_HDR: if (rd_valid) begin
          if (id_in == TARGET_ID) begin
            state <= S_LCAP;
            rd_req <= 1'b1;
            rd_addr <= base[7:2] + 6'd3;
          end else if (nxt_in == 8'h00) begin
            state <= S_IDLE;
            done <= 1'b1;
          end else if (hops == HOP_W'(MAX_HOPS - 1)) begin
            error <= 1'b1;
            state <= S_IDLE;
            done <= 1'b1;
          end else begin
            hops <= hops + 1'b1;
            base <= nxt_in;
            rd_req <= 1'b1;
            rd_addr <= nxt_in[7:2];
          end
        end
        S_LCAP: if (rd_valid) begin
          max_speed <= rd_data[3:0];
          max_width <= rd_data[9:4];
          state <= S_LSTS;
          rd_req <= 1'b1;
          rd_addr <= base[7:2] + 6'd4;
        end
        S_LSTS: if (rd_valid) begin
          cur_speed <= rd_data[19:16];
          cur_width <= rd_data[25:20];
          cap_base <= base;
          found <= 1'b1;
          state <= S_IDLE;
          done <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r1_first_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start) |=> (rd_req && rd_addr == STAT_DW));
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !rd_req);
  a_r5_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (cap_base[1:0] == 2'b00 && cap_base != 8'h00));
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(found && error));
  a_r8_hop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hops < HOP_W'(MAX_HOPS));
  a_r9_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rd_valid));
endmodule

// File: tb/cfg_cap_walker_test.sv
`timescale 1ns/1ps
module cfg_cap_walker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rd_req, rd_valid;
  logic [5:0] rd_addr;
  logic [31:0] rd_data;
  logic done, found, error, max_width_ok, cur_width_ok;
  logic [7:0] cap_base;
  logic [3:0] max_speed, cur_speed;
  logic [5:0] max_width, cur_width;

  always #10 clk = ~clk;

  cfg_cap_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .found(found), .error(error), .cap_base(cap_base),
    .max_speed(max_speed), .max_width(max_width), .max_width_ok(max_width_ok),
    .cur_speed(cur_speed), .cur_width(cur_width), .cur_width_ok(cur_width_ok)
  );

  logic [31:0] mem [64];
  int lat = 1;
  int cnt = 0;
  logic [5:0] paddr = '0;
  int tot_reads = 0;
  int snap = 0;
  logic [5:0] first_addr = '0;
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  initial begin
    rd_valid = 1'b0;
    rd_data = '0;
  end

  always @(posedge clk) begin
    rd_valid <= 1'b0;
    if (rd_req) begin
      paddr <= rd_addr;
      cnt <= lat;
      if (tot_reads == snap) first_addr <= rd_addr;
      tot_reads <= tot_reads + 1;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        rd_valid <= 1'b1;
        rd_data <= mem[paddr];
      end
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic prev_v = 1'b0, prev_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n && done) begin
      check(prev_v, "R9 done follows data-valid", int'(prev_v), 1);
      check(!prev_d, "R9 done single cycle", int'(prev_d), 0);
    end
    prev_v <= rd_valid;
    prev_d <= done;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  typedef struct packed {
    logic        stat;
    logic [7:0]  p0;
    logic [7:0]  id0;
    logic [7:0]  n0;
    logic [7:0]  id1;
    logic [15:0] lcap;
    logic [15:0] lsts;
    logic [1:0]  vlat;
    logic        ef;
    logic [7:0]  eb;
    logic [7:0]  er;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 8'h40, 8'h10, 8'h00, 8'h00, 16'h0043, 16'h0043, 2'd1, 1'b1, 8'h40, 8'd5},
    '{1'b1, 8'h43, 8'h01, 8'h62, 8'h10, 16'h0083, 16'h0022, 2'd2, 1'b1, 8'h60, 8'd6},
    '{1'b1, 8'h40, 8'h05, 8'h60, 8'h11, 16'h0000, 16'h0000, 2'd3, 1'b0, 8'h00, 8'd4},
    '{1'b0, 8'h40, 8'h10, 8'h00, 8'h00, 16'h0043, 16'h0043, 2'd1, 1'b0, 8'h00, 8'd1},
    '{1'b1, 8'h00, 8'h10, 8'h00, 8'h00, 16'h0043, 16'h0043, 2'd2, 1'b0, 8'h00, 8'd2},
    '{1'b1, 8'h80, 8'h10, 8'h00, 8'h00, 16'h00C4, 16'h0005, 2'd1, 1'b1, 8'h80, 8'd5},
    '{1'b1, 8'hA0, 8'h10, 8'h00, 8'h00, 16'h0201, 16'h0031, 2'd3, 1'b1, 8'hA0, 8'd5}
  };

  function automatic logic legal_w(input logic [5:0] w);
    return (w == 1 || w == 2 || w == 4 || w == 8 || w == 12 || w == 16 || w == 32);
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
  endtask

  task automatic load(input vec_t v);
    clear_mem();
    mem[1] = v.stat ? 32'h0010_0000 : 32'hFFEF_FFFF;
    mem[13] = {24'hA5A5A5, v.p0};
    if (v.p0[7:2] != 0) mem[v.p0[7:2]] = {16'h1234, v.n0, v.id0};
    if (v.n0[7:2] != 0) mem[v.n0[7:2]] = {16'h1234, 8'h00, v.id1};
    if (v.ef) begin
      mem[v.eb[7:2] + 3] = {16'hBEEF, v.lcap};
      mem[v.eb[7:2] + 4] = {v.lsts, 16'hFFFF};
    end
  endtask

  task automatic run(input int l, input logic poke_busy, output int nreads);
    int waited;
    lat = l;
    @(negedge clk);
    snap = tot_reads;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 2000) begin
      @(negedge clk);
      waited++;
      if (poke_busy && waited == 3) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    check(done, "R9 done arrives", int'(done), 1);
    nreads = tot_reads - snap;
  endtask

  initial begin
    int nr;
    clear_mem();
    repeat (3) @(negedge clk);
    check(!rd_req && !done && !found && !error, "R10 reset controls", int'({rd_req, done, found, error}), 0);
    check(cap_base == 0 && max_speed == 0 && max_width == 0 && cur_speed == 0 && cur_width == 0,
          "R10 reset fields", int'(cap_base), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = TBL[k];
      load(v);
      run(int'(v.vlat), 1'b0, nr);
      check(first_addr == 6'd1, "R1 first read is status dword", int'(first_addr), 1);
      check(nr == int'(v.er), "R2 R3 R4 read count", nr, int'(v.er));
      check(found == v.ef, "R4 found", int'(found), int'(v.ef));
      check(!error, "R8 no error on short chain", int'(error), 0);
      check(cap_base == (v.ef ? v.eb : 8'h00), "R5 cap_base", int'(cap_base), int'(v.ef ? v.eb : 8'h00));
      check(max_speed == (v.ef ? v.lcap[3:0] : 4'h0), "R5 max_speed", int'(max_speed), int'(v.ef ? v.lcap[3:0] : 4'h0));
      check(max_width == (v.ef ? v.lcap[9:4] : 6'h0), "R5 max_width", int'(max_width), int'(v.ef ? v.lcap[9:4] : 6'h0));
      check(cur_speed == (v.ef ? v.lsts[3:0] : 4'h0), "R6 cur_speed", int'(cur_speed), int'(v.ef ? v.lsts[3:0] : 4'h0));
      check(cur_width == (v.ef ? v.lsts[9:4] : 6'h0), "R6 cur_width", int'(cur_width), int'(v.ef ? v.lsts[9:4] : 6'h0));
      check(max_width_ok == legal_w(max_width), "R7 max_width_ok", int'(max_width_ok), int'(legal_w(max_width)));
      check(cur_width_ok == legal_w(cur_width), "R7 cur_width_ok", int'(cur_width_ok), int'(legal_w(cur_width)));
    end

    load(TBL[0]);
    run(1, 1'b0, nr);
    repeat (4) @(negedge clk);
    check(!done && found && max_speed == 4'd3 && cur_width == 6'd4, "R9 results held after done",
          int'({done, found}), 1);

    load(TBL[3]);
    run(2, 1'b0, nr);
    check(!found && max_speed == 0 && cur_width == 0 && cap_base == 0, "R9 start clears results",
          int'(max_speed), 0);
    check(nr == 1 && !error, "R2 status bit clear stops walk", nr, 1);

    load(TBL[1]);
    run(3, 1'b1, nr);
    check(nr == 6, "R1 start while busy ignored (reads)", nr, 6);
    check(found && cap_base == 8'h60 && max_width == 6'd8, "R1 start while busy ignored (result)",
          int'(cap_base), 96);
    repeat (3) @(negedge clk);
    check(tot_reads - snap == 6 && !rd_req, "R1 no second walk after busy start", tot_reads - snap, 6);

    clear_mem();
    mem[1] = 32'h0010_0000;
    mem[13] = 32'h0000_0040;
    mem[16] = {16'h0, 8'h41, 8'h01};
    run(1, 1'b0, nr);
    check(error, "R8 circular chain error", int'(error), 1);
    check(!found, "R8 circular chain not found", int'(found), 0);
    check(nr == 50, "R8 hop limit read count", nr, 50);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule